// File: doc/BRIEF.md
# Quadrature and Up/Down Position Counter

This block keeps a signed-agnostic position count driven by two external inputs, `in_a_i` and `in_b_i`. The 2-bit `mode_i` input selects how the inputs are read. Mode 0 decodes an incremental encoder's phase pair with four counts per cycle. Mode 1 reads the pair as a plain 2-bit binary number. Mode 2 counts rising edges of one input, and the level of the other input sets the direction. Mode 3 uses one input's rising edges to count up and the other's rising edges to count down.

Both inputs pass through a multi-stage synchronizer before any edges are detected, so they may come from outside the clock domain. Software can zero the count or write a new value. The block reports three things: the count, the direction of the last step that was counted, and a sticky flag. The flag is set when an encoder transition skips a state.

Top module: `qc_counter`

## Requirements
- R1: When reset is released, `count_o` is 0, `dir_o` is 0 and `err_o` is 0.
- R2: In mode 0 the code is {a,b}. The forward sequence 00→10→11→01→00, with a leading b, adds 1 on each change and sets `dir_o` to 0.
- R3: In mode 0 the reverse sequence 00→01→11→10→00, with b leading a, subtracts 1 on each change and sets `dir_o` to 1.
- R4: In mode 0 a change of both bits at once leaves the count and `dir_o` unchanged and sets `err_o`. `err_o` stays set until `clear_i`, and no other mode sets it.
- R5: In mode 1 the code {a,b} is read as a binary value. A change to value+1 mod 4 (including 3→0) adds 1. A change to value−1 mod 4 (including 0→3) subtracts 1. A change of 2 leaves the count unchanged and raises no error.
- R6: In mode 2 a rising edge of a adds 1 when b is 0 and subtracts 1 when b is 1. A falling edge of a, or any change of b alone, has no effect.
- R7: In mode 3 a rising edge of a adds 1 and a rising edge of b subtracts 1. When both rise in the same cycle there is no change, and falling edges have no effect.
- R8: The count wraps modulo 2^CNT_W in both directions.
- R9: `clear_i` zeroes the count and `err_o`, and it takes priority over `load_i`. `load_i` writes `load_val_i`. A step that arrives in a cycle with `clear_i` or `load_i` is discarded, and neither input changes `dir_o`.
- R10: A change on the pins shows in `count_o` after the (SYNC_STAGES+1)-th rising clock edge that follows it, and not before.
- R11: `dir_o` changes only with a counted step and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Mode: 0 quadrature, 1 binary, 2 level direction, 3 separate up/down edges |
| in_a_i | input | 1 | Input a (asynchronous) |
| in_b_i | input | 1 | Input b (asynchronous) |
| clear_i | input | 1 | Zero the count and the error flag |
| load_i | input | 1 | Write `load_val_i` into the count |
| load_val_i | input | CNT_W | Value to write |
| count_o | output | CNT_W | Current count |
| dir_o | output | 1 | Direction of the last counted step, 1 = down |
| err_o | output | 1 | Sticky flag for a skipped quadrature state |

## Verification
The bench builds the counter with CNT_W = 8 and SYNC_STAGES = 2. At that width a random walk of a few hundred steps crosses the wrap point in both directions by itself, and a load of 255 or 0 reaches the wrap at once. With two synchronizer stages the exact latency is three edges, and the bench checks that on both sides of the edge. Random mode switches happen while the inputs are stable, which tests that edge history carries over from one mode to the next.

// File: rtl/qc_pkg.sv
package qc_pkg;

    typedef enum logic [1:0] {
        MODE_QUAD   = 2'd0,
        MODE_BIN    = 2'd1,
        MODE_DIRLVL = 2'd2,
        MODE_UPDN   = 2'd3
    } qc_mode_e;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2,
        STEP_BAD  = 2'd3
    } qc_step_e;

    // position of a quadrature code {a,b} along the forward cycle
    function automatic logic [1:0] quad_pos(input logic [1:0] code);
        case (code)
            2'b00:   quad_pos = 2'd0;
            2'b10:   quad_pos = 2'd1;
            2'b11:   quad_pos = 2'd2;
            default: quad_pos = 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/qc_sync.sv
module qc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stg
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[i] <= '0;
                else        stg_q[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[i] <= '0;
                else        stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/qc_step_decode.sv
module qc_step_decode
    import qc_pkg::*;
(
    input  qc_mode_e   mode,
    input  logic [1:0] prev,
    input  logic [1:0] cur,
    output qc_step_e   step
);
    logic [1:0] dq;
    logic [1:0] db;
    logic       rise_a;
    logic       rise_b;

    always_comb begin
        dq     = quad_pos(cur) - quad_pos(prev);
        db     = cur - prev;
        rise_a = !prev[1] && cur[1];
        rise_b = !prev[0] && cur[0];
        step   = STEP_NONE;
        case (mode)
            MODE_QUAD: begin
                case (dq)
                    2'd1:    step = STEP_UP;
                    2'd3:    step = STEP_DN;
                    2'd2:    step = STEP_BAD;
                    default: step = STEP_NONE;
                endcase
            end
            MODE_BIN: begin
                case (db)
                    2'd1:    step = STEP_UP;
                    2'd3:    step = STEP_DN;
                    default: step = STEP_NONE;
                endcase
            end
            MODE_DIRLVL: begin
                if (rise_a) step = cur[0] ? STEP_DN : STEP_UP;
            end
            default: begin
                if (rise_a && !rise_b)      step = STEP_UP;
                else if (rise_b && !rise_a) step = STEP_DN;
            end
        endcase
    end
endmodule

// File: rtl/qc_counter.sv
module qc_counter
    import qc_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             in_a_i,
    input  logic             in_b_i,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_o,
    output logic             err_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [1:0]       prev;
        logic             dir;
        logic             err;
    } state_t;

    state_t     st_d, st_q;
    logic [1:0] code_sync;
    qc_step_e   step;

    qc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({in_a_i, in_b_i}),
        .q     (code_sync)
    );

    qc_step_decode u_dec (
        .mode (qc_mode_e'(mode_i)),
        .prev (st_q.prev),
        .cur  (code_sync),
        .step (step)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = code_sync;
        if (clear_i) begin
            st_d.cnt = '0;
            st_d.err = 1'b0;
        end else if (load_i) begin
            st_d.cnt = load_val_i;
        end else begin
            case (step)
                STEP_UP: begin
                    st_d.cnt = st_q.cnt + ONE;
                    st_d.dir = 1'b0;
                end
                STEP_DN: begin
                    st_d.cnt = st_q.cnt - ONE;
                    st_d.dir = 1'b1;
                end
                STEP_BAD: st_d.err = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign dir_o   = st_q.dir;
    assign err_o   = st_q.err;
endmodule

// File: rtl/qc_counter_chk.sv
module qc_counter_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_i,
    input logic             clear_i,
    input logic             load_i,
    input logic [CNT_W-1:0] load_val_i,
    input logic [CNT_W-1:0] count_o,
    input logic             dir_o,
    input logic             err_o
);
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !clear_i) |=> err_o);

    a_r4_err_quad_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> ($past(mode_i) == 2'd0));

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (count_o == '0 && !err_o && $stable(dir_o)));

    a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clear_i) |=> (count_o == $past(load_val_i) && $stable(dir_o)));

    a_r8_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !clear_i) |=> (count_o == $past(count_o)
            || count_o == CNT_W'($past(count_o) + 1'b1)
            || count_o == CNT_W'($past(count_o) - 1'b1)));

    a_r11_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !clear_i) |=> (count_o != $past(count_o) || $stable(dir_o)));

    a_r2_up_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !clear_i) |=> (count_o != CNT_W'($past(count_o) + 1'b1) || !dir_o));

    a_r3_down_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !clear_i) |=> (count_o != CNT_W'($past(count_o) - 1'b1) || dir_o));
endmodule

bind qc_counter qc_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .clear_i    (clear_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .count_o    (count_o),
    .dir_o      (dir_o),
    .err_o      (err_o)
);

// File: tb/sim_qc_counter.sv
module sim_qc_counter;
    localparam int CNT_W = 8;
    localparam int SYNC  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode = 2'd0;
    logic             a = 1'b0, b = 1'b0;
    logic             clr = 1'b0, ld = 1'b0;
    logic [CNT_W-1:0] ld_val = '0;
    logic [CNT_W-1:0] count;
    logic             dir, err;

    int checks = 0;
    int fails  = 0;
    logic [CNT_W-1:0] e_cnt = '0;
    logic             e_dir = 1'b0, e_err = 1'b0;
    logic [1:0]       e_prev = 2'b00;

    always #2 clk = ~clk;

    qc_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .in_a_i(a), .in_b_i(b),
        .clear_i(clr), .load_i(ld), .load_val_i(ld_val),
        .count_o(count), .dir_o(dir), .err_o(err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_step(input logic [1:0] m, input logic [1:0] p,
                                      input logic [1:0] c, output bit bad);
        int pp, cc, d;
        bad = 0;
        case (m)
            2'd0: begin
                pp = (p == 2'b00) ? 0 : (p == 2'b10) ? 1 : (p == 2'b11) ? 2 : 3;
                cc = (c == 2'b00) ? 0 : (c == 2'b10) ? 1 : (c == 2'b11) ? 2 : 3;
                d = (cc - pp + 4) % 4;
                if (d == 2) bad = 1;
                return (d == 1) ? 1 : (d == 3) ? -1 : 0;
            end
            2'd1: begin
                d = (int'(c) - int'(p) + 4) % 4;
                return (d == 1) ? 1 : (d == 3) ? -1 : 0;
            end
            2'd2: begin
                if (!p[1] && c[1]) return c[0] ? -1 : 1;
                return 0;
            end
            default: begin
                if (!p[1] && c[1] && !(!p[0] && c[0])) return 1;
                if (!p[0] && c[0] && !(!p[1] && c[1])) return -1;
                return 0;
            end
        endcase
    endfunction

    task automatic check_all(input string tag);
        chk({tag, " count"}, 32'(count), 32'(e_cnt));
        chk({tag, " dir"},   32'(dir),   32'(e_dir));
        chk({tag, " err"},   32'(err),   32'(e_err));
    endtask

    task automatic apply(input logic na, input logic nb, input string tag);
        int  s;
        bit  bad;
        @(negedge clk);
        a = na; b = nb;
        s = model_step(mode, e_prev, {na, nb}, bad);
        e_prev = {na, nb};
        if (bad) e_err = 1'b1;
        if (s != 0) begin
            e_cnt = e_cnt + CNT_W'(s);
            e_dir = (s < 0);
        end
        repeat (SYNC + 2) @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic do_load(input logic [CNT_W-1:0] v, input string tag);
        @(negedge clk);
        ld = 1'b1; ld_val = v;
        @(negedge clk);
        ld = 1'b0;
        e_cnt = v;
        check_all(tag);
    endtask

    task automatic do_clear(input string tag);
        @(negedge clk);
        clr = 1'b1; ld = 1'b1; ld_val = 8'hA5;
        @(negedge clk);
        clr = 1'b0; ld = 1'b0;
        e_cnt = '0; e_err = 1'b0;
        check_all(tag);
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode = m;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R2 forward quadrature
        apply(1, 0, "R2"); apply(1, 1, "R2"); apply(0, 1, "R2"); apply(0, 0, "R2");
        // R3 reverse quadrature
        apply(0, 1, "R3"); apply(1, 1, "R3"); apply(1, 0, "R3");
        // R4 skipped state: 10 -> 01
        apply(0, 1, "R4 illegal");
        apply(0, 0, "R4 sticky");
        do_clear("R9 clear beats load");

        // R8 wrap down and up
        apply(0, 1, "R8 wrap down");
        apply(0, 0, "R8 wrap up");

        // R10 latency: 00 -> 10 in mode 0
        @(negedge clk);
        a = 1'b1;
        repeat (SYNC) @(posedge clk);
        @(negedge clk);
        chk("R10 before", 32'(count), 32'(e_cnt));
        @(posedge clk);
        @(negedge clk);
        e_cnt = e_cnt + 1'b1; e_dir = 1'b0; e_prev = 2'b10;
        chk("R10 at edge", 32'(count), 32'(e_cnt));
        apply(0, 0, "R2 back");

        // R5 binary
        set_mode(2'd1);
        apply(1, 1, "R5 0 to 3");
        apply(0, 0, "R5 3 to 0");
        apply(1, 0, "R5 step of two");
        apply(0, 1, "R5 2 to 1");

        // R6 level direction
        set_mode(2'd2);
        apply(0, 0, "R6 b fall");
        apply(1, 0, "R6 a rise up");
        apply(0, 0, "R6 a fall");
        apply(0, 1, "R6 b only");
        apply(1, 1, "R6 a rise down");

        // R7 separate edges
        set_mode(2'd3);
        apply(0, 0, "R7 falls");
        apply(1, 1, "R7 both rise");
        apply(0, 1, "R7 a fall");
        apply(1, 1, "R7 a rise");
        apply(1, 0, "R7 b fall");
        apply(1, 1, "R7 b rise");
        chk("R11 dir after down", 32'(dir), 32'(1));

        // R9 load near the top, then R8 wrap
        set_mode(2'd0);
        apply(0, 0, "R11 no step");
        do_load(8'hFF, "R9 load");
        apply(1, 0, "R8 wrap via load");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int r;
            if (it % 50 == 0) set_mode(2'($urandom % 4));
            r = $urandom % 12;
            if (r == 0)      do_load(CNT_W'($urandom), "R9 random load");
            else if (r == 1) do_clear("R9 random clear");
            else             apply(1'($urandom), 1'($urandom), "R11 random");
        end
        finish_run();
    end
endmodule